// File: doc/BRIEF.md
# Supply-guarded byte-wide static memory

This block is a clocked model of a byte-wide static memory. It turns the three active-low strobes into one operating mode per cycle. With the chip strobe high the part is deselected. With chip and write strobes low it writes. With chip and output strobes low and the write strobe high it reads. With chip strobe low and both other strobes high it stays active but keeps its outputs off. All strobes, the address and the write data are sampled on the rising clock edge. The mode, read data and output enable come out of registers one cycle later. A write is held in a small pending register and is stored into the array in the cycle in which the strobes leave the write pattern.

Two digital flags from an external supply comparator are brought in through synchronisers. One flag means the supply is below the power-fail level. The other means it is below the battery switchover level. Either flag overrides the strobe decode. The array is write-protected, the outputs are released, and the mode reports a protected standby or battery backup state. A write still pending when the fault is recognised is dropped. After both flags clear, a hold-off counter keeps the memory protected for a set number of cycles before the strobes are accepted again. The full 19-bit address is accepted. For simulation the array depth is reduced, and the address chunks are folded onto a smaller index.

Top module: `supply_guarded_sram`

## Requirements
- R1: With e_ni high, mode_o reads 0 (deselect), oe_o is 0 and rdata_o is 0 one cycle later, whatever g_ni and w_ni are, and no byte is stored.
- R2: With e_ni and w_ni low, mode_o reads 1 (write) one cycle later, whatever g_ni is. The last sampled wdata_i is stored at the last sampled address when the strobes leave that pattern.
- R3: With e_ni and g_ni low and w_ni high, mode_o reads 2 (read), oe_o is 1 and rdata_o carries the stored byte at addr_i, all one cycle after sampling.
- R4: With e_ni low and g_ni and w_ni high, mode_o reads 3 (output disabled), with oe_o and rdata_o at 0.
- R5: A read sampled in the cycle that ends a write to the same address returns the newly written byte.
- R6: From the third rising edge after pfail_i rises, mode_o reads 4 (protected standby), oe_o and rdata_o are 0, and strobes neither read nor write.
- R7: From the third rising edge after bkup_i rises, mode_o reads 5 (battery backup). Bytes written before the fault read back unchanged after recovery.
- R8: bkup_i high with pfail_i low is treated as battery backup: mode_o reads 5 from the third edge.
- R9: After both flags clear, mode_o stays 4 up to and including edge HOLDOFF+2, and follows the strobes from edge HOLDOFF+3. A write pulse during the hold-off is not stored.
- R10: A write whose strobes are still asserted when the fault is recognised is never stored, even when the strobes are released later.
- R11: During and after reset mode_o reads 4 and oe_o is 0. With both flags low the strobes are accepted from the HOLDOFF+3rd edge after reset release.
- R12: Addresses that differ only in bits 8 and up reach separate bytes whenever the XOR of their 8-bit address chunks differs (for example 0x00123 and 0x40123).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 19 | Byte address |
| wdata_i | input | 8 | Write data |
| e_ni | input | 1 | Chip strobe, active low |
| g_ni | input | 1 | Output strobe, active low |
| w_ni | input | 1 | Write strobe, active low |
| pfail_i | input | 1 | Supply below power-fail level (asynchronous) |
| bkup_i | input | 1 | Supply below battery switchover level (asynchronous) |
| rdata_o | output | 8 | Read data, zero when not reading |
| oe_o | output | 1 | Enable for an external tri-state data driver |
| mode_o | output | 3 | Operating mode: 0 deselect, 1 write, 2 read, 3 output disabled, 4 protected standby, 5 battery backup |

## Verification
The hardest case to reach is a write that is still open when a supply fault arrives, together with the recovery that follows. The stimulus holds the write strobes low while pfail_i rises and keeps them low until the protected mode shows. It then releases them, escalates to battery backup, and fires a write pulse inside the hold-off window. Reads afterwards prove that neither write reached the array and that the older bytes survived. The edge on which the strobes are accepted again is checked on both sides of the boundary.

// File: rtl/sram_guard_pkg.sv
package sram_guard_pkg;
  typedef enum logic [2:0] {
    MODE_DESEL  = 3'd0,
    MODE_WRITE  = 3'd1,
    MODE_READ   = 3'd2,
    MODE_OUTDIS = 3'd3,
    MODE_PROT   = 3'd4,
    MODE_BATT   = 3'd5
  } mode_e;
endpackage

// File: rtl/supply_monitor.sv
module supply_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLDOFF     = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pfail_i,
  input  logic bkup_i,
  output logic prot_o,
  output logic batt_o
);
  localparam int CNT_W = $clog2(HOLDOFF + 1);

  logic [SYNC_STAGES-1:0] pf_q, bk_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   fault;

  // power assumed bad until the synchronisers fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q <= '1;
      bk_q <= '0;
    end else begin
      pf_q <= {pf_q[SYNC_STAGES-2:0], pfail_i};
      bk_q <= {bk_q[SYNC_STAGES-2:0], bkup_i};
    end
  end

  assign fault = pf_q[SYNC_STAGES-1] | bk_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CNT_W'(HOLDOFF);
    else if (fault)          cnt_q <= CNT_W'(HOLDOFF);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  // switchover flag alone still means battery backup
  assign batt_o = bk_q[SYNC_STAGES-1];
  assign prot_o = fault | (cnt_q != '0);

  p_holdoff_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault) |-> cnt_q == CNT_W'(HOLDOFF));
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import sram_guard_pkg::*;
(
  input  logic  e_ni,
  input  logic  g_ni,
  input  logic  w_ni,
  input  logic  prot_i,
  input  logic  batt_i,
  output mode_e mode_o
);
  always_comb begin
    if (batt_i)      mode_o = MODE_BATT;
    else if (prot_i) mode_o = MODE_PROT;
    else if (e_ni)   mode_o = MODE_DESEL;
    else if (!w_ni)  mode_o = MODE_WRITE;
    else if (!g_ni)  mode_o = MODE_READ;
    else             mode_o = MODE_OUTDIS;
  end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[widx_i] <= wdata_i;
  end

  // forward a byte committed in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_o <= '0;
    else if (!re_i)                       rdata_o <= '0;
    else if (we_i && (widx_i == ridx_i))  rdata_o <= wdata_i;
    else                                  rdata_o <= mem[ridx_i];
  end
endmodule

// File: rtl/supply_guarded_sram.sv
module supply_guarded_sram
  import sram_guard_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLDOFF     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              e_ni,
  input  logic              g_ni,
  input  logic              w_ni,
  input  logic              pfail_i,
  input  logic              bkup_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o,
  output logic [2:0]        mode_o
);
  localparam int NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  logic              prot, batt, commit;
  mode_e             dec, mode_q;
  logic              oe_q, pend_q;
  logic [IDX_W-1:0]  pidx_q, idx;
  logic [DATA_W-1:0] pdata_q;
  logic [PAD_W-1:0]  addr_pad;
  logic [IDX_W-1:0]  chunk [NCHUNK];

  supply_monitor #(.SYNC_STAGES(SYNC_STAGES), .HOLDOFF(HOLDOFF)) u_mon (
    .clk_i, .rst_ni, .pfail_i, .bkup_i, .prot_o(prot), .batt_o(batt)
  );

  strobe_decode u_dec (
    .e_ni, .g_ni, .w_ni, .prot_i(prot), .batt_i(batt), .mode_o(dec)
  );

  // fold the wide address onto the reduced array
  assign addr_pad = PAD_W'(addr_i);
  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    assign chunk[c] = addr_pad[c*IDX_W +: IDX_W];
  end
  always_comb begin
    idx = '0;
    for (int c = 0; c < NCHUNK; c++) idx ^= chunk[c];
  end

  assign commit = pend_q && !prot && (dec != MODE_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pidx_q  <= '0;
      pdata_q <= '0;
    end else if (prot) begin
      pend_q  <= 1'b0;               // abort open write
    end else if (dec == MODE_WRITE) begin
      pend_q  <= 1'b1;
      pidx_q  <= idx;
      pdata_q <= wdata_i;
    end else begin
      pend_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_PROT;
      oe_q   <= 1'b0;
    end else begin
      mode_q <= dec;
      oe_q   <= (dec == MODE_READ);
    end
  end

  sram_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni,
    .we_i(commit), .widx_i(pidx_q), .wdata_i(pdata_q),
    .re_i(dec == MODE_READ), .ridx_i(idx), .rdata_o
  );

  assign oe_o   = oe_q;
  assign mode_o = mode_q;

  p_oe_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> mode_o == MODE_READ);
  p_desel_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_DESEL) |-> (!oe_o && rdata_o == '0));
  p_fault_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_PROT || mode_o == MODE_BATT) |-> (!oe_o && rdata_o == '0));
  p_fault_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot |=> (mode_o == MODE_PROT || mode_o == MODE_BATT));
  p_batt_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt |=> mode_o == MODE_BATT);
  p_commit_after_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> mode_o == MODE_WRITE);
endmodule

// File: tb/supply_guarded_sram_bench.sv
`timescale 1ns/1ps
module supply_guarded_sram_bench;
  localparam int H = 16;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        e_n = 1'b1, g_n = 1'b1, w_n = 1'b1, pf = 1'b0, bk = 1'b0;
  logic [7:0]  rdata;
  logic        oe;
  logic [2:0]  mode;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] m;
    logic       o;
    logic [7:0] d;
    string      tag;
  } exp_t;
  exp_t q[$];

  localparam logic [2:0] DS = 3'd0, WR = 3'd1, RD = 3'd2, OD = 3'd3, PR = 3'd4, BT = 3'd5;
  localparam logic [18:0] A1 = 19'h00123, A2 = 19'h7FF45, A3 = 19'h00067, A4 = 19'h40123;

  always #(CYC/2) clk = ~clk;

  supply_guarded_sram u_supply_guarded_sram (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wdata_i(wdata),
    .e_ni(e_n), .g_ni(g_n), .w_ni(w_n), .pfail_i(pf), .bkup_i(bk),
    .rdata_o(rdata), .oe_o(oe), .mode_o(mode)
  );

  task automatic step(input logic e, g, w, input logic [18:0] a, input logic [7:0] d,
                      input logic p, b, input logic [2:0] em, input logic eo,
                      input logic [7:0] ed, input string tag);
    exp_t it;
    @(negedge clk);
    e_n = e; g_n = g; w_n = w; addr = a; wdata = d; pf = p; bk = b;
    it.m = em; it.o = eo; it.d = ed; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (mode !== it.m || oe !== it.o || rdata !== it.d) begin
          errors++;
          $display("FAIL %s: mode=%0d oe=%0b rdata=%h expected mode=%0d oe=%0b rdata=%h",
                   it.tag, mode, oe, rdata, it.m, it.o, it.d);
        end
      end
    end
  end

  // flags cleared at step j=first; edge j+1 after clearing is checked
  task automatic recover(input int first, input bit was_batt, input string tag);
    for (int j = first; j <= H + 3; j++) begin
      logic [2:0] em;
      if (j <= 1)          em = was_batt ? BT : PR;
      else if (j <= H + 1) em = PR;
      else                 em = DS;
      if (j == 2) step(0, 1, 0, A1, 8'hEE, 0, 0, em, 0, 8'h00, {tag, " R9 holdoff write"});
      else        step(1, 0, 0, A1, 8'hEE, 0, 0, em, 0, 8'h00,
                       (j >= H + 1) ? {tag, " R9 boundary"} : tag);
    end
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (mode !== PR || oe !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: mode=%0d oe=%0b expected mode=4 oe=0", mode, oe);
    end
    rst_ni = 1'b1;
    recover(1, 1'b0, "R11 after reset");

    // R2 writes, G don't care; R1 deselect releases
    step(0, 0, 0, A1, 8'h5A, 0, 0, WR, 0, 8'h00, "R2 write g low");
    step(1, 0, 0, A1, 8'h00, 0, 0, DS, 0, 8'h00, "R1 deselect g,w low");
    step(0, 1, 0, A2, 8'hC3, 0, 0, WR, 0, 8'h00, "R2 write g high");
    step(1, 1, 1, A2, 8'h00, 0, 0, DS, 0, 8'h00, "R1 deselect");
    step(0, 0, 1, A1, 8'h00, 0, 0, RD, 1, 8'h5A, "R3 read A1");
    step(0, 0, 1, A2, 8'h00, 0, 0, RD, 1, 8'hC3, "R3 read A2");
    step(0, 1, 1, A1, 8'h00, 0, 0, OD, 0, 8'h00, "R4 output disabled");
    // R5 read in the cycle that ends the write
    step(0, 1, 0, A3, 8'h3C, 0, 0, WR, 0, 8'h00, "R2 write A3");
    step(0, 0, 1, A3, 8'h00, 0, 0, RD, 1, 8'h3C, "R5 forward");
    step(0, 0, 1, A3, 8'h00, 0, 0, RD, 1, 8'h3C, "R2 stored A3");
    // R12 upper address bits
    step(0, 1, 0, A4, 8'h99, 0, 0, WR, 0, 8'h00, "R12 write A4");
    step(1, 1, 1, A4, 8'h00, 0, 0, DS, 0, 8'h00, "R12 release");
    step(0, 0, 1, A1, 8'h00, 0, 0, RD, 1, 8'h5A, "R12 A1 kept");
    step(0, 0, 1, A4, 8'h00, 0, 0, RD, 1, 8'h99, "R12 A4");
    // R1 deselected write attempt
    step(1, 1, 0, A1, 8'hFF, 0, 0, DS, 0, 8'h00, "R1 deselect w low");
    step(1, 1, 1, A1, 8'hFF, 0, 0, DS, 0, 8'h00, "R1 idle");
    step(0, 0, 1, A1, 8'h00, 0, 0, RD, 1, 8'h5A, "R1 no store");

    // R6 / R10 fault during an open write
    step(0, 1, 0, A2, 8'h11, 1, 0, WR, 0, 8'h00, "R6 edge1");
    step(0, 1, 0, A2, 8'h11, 1, 0, WR, 0, 8'h00, "R6 edge2");
    step(0, 1, 0, A2, 8'h11, 1, 0, PR, 0, 8'h00, "R6 edge3");
    step(1, 1, 1, A2, 8'h11, 1, 0, PR, 0, 8'h00, "R10 release");
    step(0, 0, 1, A1, 8'h00, 1, 0, PR, 0, 8'h00, "R6 read blocked");
    // R7 battery
    step(1, 1, 1, A1, 8'h00, 1, 1, PR, 0, 8'h00, "R7 edge1");
    step(1, 1, 1, A1, 8'h00, 1, 1, PR, 0, 8'h00, "R7 edge2");
    step(0, 0, 1, A1, 8'h00, 1, 1, BT, 0, 8'h00, "R7 edge3");
    step(0, 1, 0, A1, 8'h77, 1, 1, BT, 0, 8'h00, "R7 write blocked");
    recover(0, 1'b1, "R7 recover");
    step(0, 0, 1, A2, 8'h00, 0, 0, RD, 1, 8'hC3, "R10 aborted write");
    step(0, 0, 1, A1, 8'h00, 0, 0, RD, 1, 8'h5A, "R7 retained / R9 ignored");

    // R8 inconsistent flags
    step(1, 1, 1, A1, 8'h00, 0, 1, DS, 0, 8'h00, "R8 edge1");
    step(1, 1, 1, A1, 8'h00, 0, 1, DS, 0, 8'h00, "R8 edge2");
    step(1, 1, 1, A1, 8'h00, 0, 1, BT, 0, 8'h00, "R8 edge3");
    recover(0, 1'b1, "R8 recover");
    step(0, 0, 1, A3, 8'h00, 0, 0, RD, 1, 8'h3C, "R8 retained");

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule